// File: doc/BRIEF.md
# PCI Bus Mode and Width Reset Detector

This block watches the bus-initialization straps that the host bridge drives while it releases the system reset. It works out two things: whether the segment runs conventional PCI or PCI-X, and whether it is 32 or 64 bits wide. It samples the five strap lines once, on the PCI clock edge where the active-low reset is first seen high. It then holds its three result flags unchanged until the reset is asserted again.

Two independent manual overrides let the surrounding logic pin the operating mode or the bus width, whatever the straps say. Mode detection keeps running while the mode is pinned. If the pinned mode disagrees with the mode the straps report, the block raises a reconfigure request. An external loader can then swap in a configuration built for the other mode.

Top module: `pci_bus_strap_detect`

## Requirements
- R1: With the width override low, `wide_en` after reset release is 1 when `req64_n` was 0 on the release edge, and 0 when it was 1.
- R2: With the mode override low, `pcix_en` after release is 1 when, on the release edge, `perr_n` and `devsel_n` were both 1 and at least one of `stop_n` or `trdy_n` was 0.
- R3: With the mode override low, every other strap pattern, including all four lines at 1, gives `pcix_en` = 0 (conventional PCI).
- R4: With `mode_force` = 1 on the release edge, `pcix_en` equals the inverse of `manual_pci` (1 selects PCI, 0 selects PCI-X). With `mode_force` = 0, `manual_pci` has no effect on `pcix_en`.
- R5: With `width_force` = 1 on the release edge, `wide_en` equals the inverse of `manual_32` (1 selects 32-bit, 0 selects 64-bit), and `req64_n` is ignored. With `width_force` = 0, `manual_32` has no effect.
- R6: `reconfig_req` is 1 after release exactly when `mode_force` was 1 and the pinned mode differs from the mode decoded from the straps. It is 0 whenever `mode_force` was 0.
- R7: At every clock edge while `rst_n` is 0, all three outputs are cleared to 0 (32-bit, PCI, no request).
- R8: From the cycle after the release edge until `rst_n` falls again, all three outputs stay stable, whatever the strap and override inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI bus clock |
| rst_n | input | 1 | Bus system reset, active low; its rising edge is the sampling point |
| req64_n | input | 1 | 64-bit request strap, active low |
| perr_n | input | 1 | Parity-error line used as a mode strap |
| devsel_n | input | 1 | Device-select line used as a mode strap |
| stop_n | input | 1 | Stop line used as a mode strap |
| trdy_n | input | 1 | Target-ready line used as a mode strap |
| mode_force | input | 1 | Take the mode from `manual_pci` instead of the straps |
| manual_pci | input | 1 | Pinned mode: 1 = PCI, 0 = PCI-X |
| width_force | input | 1 | Take the width from `manual_32` instead of `req64_n` |
| manual_32 | input | 1 | Pinned width: 1 = 32-bit, 0 = 64-bit |
| pcix_en | output | 1 | Operating in PCI-X mode |
| wide_en | output | 1 | Operating 64 bits wide |
| reconfig_req | output | 1 | Pinned mode disagrees with the detected bus mode |

## Verification
Strap decoding, both overrides and the wrong-mode comparison are all resolved on the single release edge. In that one cycle the block must pin the mode and also compare the pinned value against the live decode of the straps. The bench provokes this by sweeping every combination of the five straps and the four override inputs through a full reset and release. For each case it computes the expected mode, width and request from the requirement formulas. After release it inverts every input and expects all three flags to stay frozen.

// File: rtl/pci_strap_pkg.sv
// Shared types for the bus-strap detector.
// Assumes straps are sampled as active-low bus lines.
package pci_strap_pkg;
    typedef enum logic {
        BUS_PCI  = 1'b0,
        BUS_PCIX = 1'b1
    } bus_mode_e;

    typedef struct packed {
        logic perr_n;
        logic devsel_n;
        logic stop_n;
        logic trdy_n;
    } mode_strap_t;

    localparam int STRAP_W = $bits(mode_strap_t);
endpackage

// File: rtl/pci_release_edge.sv
// Finds the PCI clock edge on which the bus reset is first seen high.
// Assumes rst_n is already synchronous to clk.
module pci_release_edge (
    input  logic clk,
    input  logic rst_n,
    output logic release_pulse
);
    logic rst_seen_q;

    // Keep last cycle's reset level for edge comparison.
    always_ff @(posedge clk) begin
        rst_seen_q <= rst_n;
    end

    assign release_pulse = rst_n & ~rst_seen_q;
endmodule

// File: rtl/pci_mode_decode.sv
// Turns the four mode straps into a bus mode.
// Any pattern that is not PCI-X counts as conventional PCI; sub-speeds are not separated.
module pci_mode_decode
    import pci_strap_pkg::*;
(
    input  mode_strap_t strap,
    output bus_mode_e   mode
);
    // PCI-X when both upper straps are high and at least one lower strap is low.
    always_comb begin
        if (strap.perr_n && strap.devsel_n && !(strap.stop_n && strap.trdy_n))
            mode = BUS_PCIX;
        else
            mode = BUS_PCI;
    end
endmodule

// File: rtl/pci_strap_latch.sv
// Applies the mode and width overrides and latches the results on the release pulse.
// Assumes synchronous active-low reset; results are held until the next reset.
module pci_strap_latch
    import pci_strap_pkg::*;
#(
    parameter bit RESET_PCIX = 1'b0,
    parameter bit RESET_WIDE = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      capture,
    input  bus_mode_e seen_mode,
    input  logic      req64_n,
    input  logic      mode_force,
    input  logic      manual_pci,
    input  logic      width_force,
    input  logic      manual_32,
    output logic      pcix_en,
    output logic      wide_en,
    output logic      reconfig_req
);
    bus_mode_e run_mode;
    logic      run_wide;
    logic      mismatch;

    // Pick the operating mode: pinned value or decoded straps.
    always_comb begin
        if (mode_force)
            run_mode = manual_pci ? BUS_PCI : BUS_PCIX;
        else
            run_mode = seen_mode;
    end

    // Pick the width: pinned value or the 64-bit request strap.
    always_comb begin
        run_wide = width_force ? ~manual_32 : ~req64_n;
    end

    // Detection runs even when the mode is pinned; flag any disagreement.
    always_comb begin
        mismatch = mode_force && (run_mode != seen_mode);
    end

    // Hold defaults in reset, capture once on release, then freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcix_en      <= RESET_PCIX;
            wide_en      <= RESET_WIDE;
            reconfig_req <= 1'b0;
        end else if (capture) begin
            pcix_en      <= (run_mode == BUS_PCIX);
            wide_en      <= run_wide;
            reconfig_req <= mismatch;
        end
    end
endmodule

// File: rtl/pci_bus_strap_detect.sv
// Top level: decodes bus mode and width from reset-release straps with manual overrides.
// Assumes all inputs are stable around the clock edge where rst_n first reads high.
module pci_bus_strap_detect
    import pci_strap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req64_n,
    input  logic perr_n,
    input  logic devsel_n,
    input  logic stop_n,
    input  logic trdy_n,
    input  logic mode_force,
    input  logic manual_pci,
    input  logic width_force,
    input  logic manual_32,
    output logic pcix_en,
    output logic wide_en,
    output logic reconfig_req
);
    logic        release_pulse;
    mode_strap_t strap;
    bus_mode_e   seen_mode;

    assign strap = '{perr_n: perr_n, devsel_n: devsel_n, stop_n: stop_n, trdy_n: trdy_n};

    pci_release_edge u_edge (
        .clk           (clk),
        .rst_n         (rst_n),
        .release_pulse (release_pulse)
    );

    pci_mode_decode u_decode (
        .strap (strap),
        .mode  (seen_mode)
    );

    pci_strap_latch #(
        .RESET_PCIX (1'b0),
        .RESET_WIDE (1'b0)
    ) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (release_pulse),
        .seen_mode    (seen_mode),
        .req64_n      (req64_n),
        .mode_force   (mode_force),
        .manual_pci   (manual_pci),
        .width_force  (width_force),
        .manual_32    (manual_32),
        .pcix_en      (pcix_en),
        .wide_en      (wide_en),
        .reconfig_req (reconfig_req)
    );
endmodule

// File: rtl/pci_bus_strap_detect_chk.sv
// Port-level properties for the strap detector, bound to the top module.
module pci_bus_strap_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic req64_n,
    input logic perr_n,
    input logic devsel_n,
    input logic stop_n,
    input logic trdy_n,
    input logic mode_force,
    input logic manual_pci,
    input logic width_force,
    input logic manual_32,
    input logic pcix_en,
    input logic wide_en,
    input logic reconfig_req
);
    logic strap_x;
    assign strap_x = perr_n && devsel_n && !(stop_n && trdy_n);

    // R7: a clock in reset leaves all outputs at default.
    p_reset_defaults_r7: assert property (@(posedge clk)
        !rst_n |=> (!pcix_en && !wide_en && !reconfig_req));

    // R8: outputs frozen once release is two cycles behind.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> $stable({pcix_en, wide_en, reconfig_req}));

    // R1/R5: width follows the override or the request strap on release.
    p_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |=>
        (wide_en == ($past(width_force) ? !$past(manual_32) : !$past(req64_n))));

    // R4: pinned mode wins.
    p_mode_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n) && mode_force) |=> (pcix_en == !$past(manual_pci)));

    // R6: request only on pinned-versus-detected disagreement.
    p_reconfig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |=>
        (reconfig_req == ($past(mode_force) && ($past(manual_pci) == $past(strap_x)))));
endmodule

bind pci_bus_strap_detect pci_bus_strap_detect_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req64_n      (req64_n),
    .perr_n       (perr_n),
    .devsel_n     (devsel_n),
    .stop_n       (stop_n),
    .trdy_n       (trdy_n),
    .mode_force   (mode_force),
    .manual_pci   (manual_pci),
    .width_force  (width_force),
    .manual_32    (manual_32),
    .pcix_en      (pcix_en),
    .wide_en      (wide_en),
    .reconfig_req (reconfig_req)
);

// File: tb/pci_bus_strap_detect_tb.sv
// Exhaustive sweep of straps and overrides through reset and release.
module pci_bus_strap_detect_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req64_n = 1'b1, perr_n = 1'b1, devsel_n = 1'b1, stop_n = 1'b1, trdy_n = 1'b1;
    logic mode_force = 1'b0, manual_pci = 1'b0, width_force = 1'b0, manual_32 = 1'b0;
    logic pcix_en, wide_en, reconfig_req;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    pci_bus_strap_detect u_dut (
        .clk(clk), .rst_n(rst_n), .req64_n(req64_n), .perr_n(perr_n),
        .devsel_n(devsel_n), .stop_n(stop_n), .trdy_n(trdy_n),
        .mode_force(mode_force), .manual_pci(manual_pci),
        .width_force(width_force), .manual_32(manual_32),
        .pcix_en(pcix_en), .wide_en(wide_en), .reconfig_req(reconfig_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic got, input logic exp, input string tag, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
        end
    endtask

    task automatic drive(input logic [8:0] v);
        {req64_n, perr_n, devsel_n, stop_n, trdy_n,
         mode_force, manual_pci, width_force, manual_32} = v;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 512; c++) begin
            logic [8:0] v;
            logic det, exp_x, exp_w, exp_r;
            v = c[8:0];
            // Reset with inverted inputs so only the release value counts.
            @(negedge clk);
            rst_n = 1'b0;
            drive(~v);
            @(negedge clk);
            @(negedge clk);
            // R7: defaults while in reset.
            check(pcix_en, 1'b0, "R7", "pcix_en in reset");
            check(wide_en, 1'b0, "R7", "wide_en in reset");
            check(reconfig_req, 1'b0, "R7", "reconfig_req in reset");
            drive(v);
            rst_n = 1'b1;
            @(negedge clk);
            // Expected values from the requirement formulas.
            det   = perr_n && devsel_n && (!stop_n || !trdy_n);
            exp_x = mode_force ? !manual_pci : det;
            exp_w = width_force ? !manual_32 : !req64_n;
            exp_r = mode_force && (manual_pci == det);
            check(pcix_en, exp_x, mode_force ? "R4" : (det ? "R2" : "R3"), "pcix_en");
            check(wide_en, exp_w, width_force ? "R5" : "R1", "wide_en");
            check(reconfig_req, exp_r, "R6", "reconfig_req");
            // R8: scramble inputs, outputs must not move.
            drive(~v);
            repeat (3) @(negedge clk);
            check(pcix_en, exp_x, "R8", "pcix_en hold");
            check(wide_en, exp_w, "R8", "wide_en hold");
            check(reconfig_req, exp_r, "R8", "reconfig_req hold");
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule